// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives a successive-approximation analogue-to-digital conversion built from parts outside the chip's logic: a trial-code DAC, a single comparator and a sample-and-hold switch. A processor starts a conversion by writing a go bit into a control register. The block then keeps the sample switch in its tracking position for a fixed acquisition time. After that it puts the switch into hold and works out the result one bit per step, starting with the most significant bit.

Each step drives a trial code to the DAC and waits a fixed number of cycles so the DAC can settle. It then reads the comparator. When the last bit is decided, the block stores the code in a result register and sets a done flag in a status register. If interrupts are enabled, it also raises an interrupt line. Reading the status register clears that interrupt.

Both durations are parameters counted in clock cycles: the acquisition time and the length of one comparison step. One conversion therefore always takes SAMPLE_CYC + RES_BITS × STEP_CYC cycles.

Top module: `sar_adc_sequencer`

## Requirements
- R1: After reset, sar_hold and irq are low, and the status and result registers read 0.
- R2: A write to the control register (offset 0) with bit 0 set, while idle, sets busy (status bit 0) and clears done (status bit 1) at the next edge. After that write edge, sar_hold stays low for exactly SAMPLE_CYC cycles.
- R3: sar_hold rises when the sample phase ends and stays high for exactly RES_BITS × STEP_CYC cycles. That is one step of STEP_CYC cycles per bit, and dac_code is stable within a step.
- R4: The first trial code has only the most significant bit set. Each later trial keeps the bits already decided and sets the next lower bit.
- R5: At the end of each step, a high cmp_hi keeps the bit under trial and a low cmp_hi clears it. With a comparator that is high when the input is at or above the trial code, the result equals the input.
- R6: Busy clears and done sets exactly SAMPLE_CYC + RES_BITS × STEP_CYC cycles after the start write edge. Once finished, dac_code holds the result.
- R7: A start write while busy is ignored: the running conversion keeps its timing and result, and busy stays set.
- R8: The result register (offset 2, low RES_BITS bits) changes only when a conversion completes. During a conversion it reads the previous result.
- R9: The control register's bit 1 enables the interrupt. At completion irq rises only if that bit is 1. Control reads return the enable in bit 1.
- R10: A read of the status register clears irq (status bit 2) at the next edge. The done bit is not affected.
- R11: Register offsets are control = 0, status = 1 and result = 2. Status bits are busy = 0, done = 1 and irq pending = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| cmp_hi | input | 1 | Comparator: input at or above the trial code |
| dac_code | output | RES_BITS | Trial code to the DAC; holds the result when idle |
| sar_hold | output | 1 | High = sample switch in hold |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Everything the bench expects is counted in edges from the start write edge. With a start write at edge k:
- Busy is set after edge k.
- sar_hold is first seen high after edge k + SAMPLE_CYC.
- The first decided trial code appears after edge k + SAMPLE_CYC + STEP_CYC.
- sar_hold falls, and done and irq appear, after edge k + SAMPLE_CYC + RES_BITS × STEP_CYC.

A driver task records the start edge number in a queue with the analogue input. A monitor samples on falling clock edges against a free-running edge counter, so each check lands in the one cycle where the value is due. Status and result reads are combinational and are sampled in the read cycle. The irq clear from a status read is checked one cycle later.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;

    // Register offsets
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_RES  = 2'd2;

    // Control bits
    localparam int CTRL_GO  = 0;
    localparam int CTRL_IEN = 1;

    // Status bits
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_IRQ  = 2;

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = 8,    // at least 2
    parameter int SAMPLE_CYC = 750,  // at least 1
    parameter int STEP_CYC   = 313   // at least 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                cmp_hi,
    output logic                busy,
    output logic                sar_hold,
    output logic [RES_BITS-1:0] dac_code,
    output logic                fin,
    output logic [RES_BITS-1:0] fin_code
);

    localparam int MAXC = (SAMPLE_CYC > STEP_CYC) ? SAMPLE_CYC : STEP_CYC;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam int IW   = $clog2(RES_BITS);

    localparam logic [CW-1:0]       SAMPLE_LD = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0]       STEP_LD   = CW'(STEP_CYC - 1);
    localparam logic [IW-1:0]       TOP_IDX   = IW'(RES_BITS - 1);
    localparam logic [RES_BITS-1:0] MSB_ONLY  = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       cnt;
        logic [IW-1:0]       idx;
        logic [RES_BITS-1:0] sar;
    } fsm_t;

    fsm_t                fsm_d, fsm_q;
    logic [IW-1:0]       idx_dn;
    logic [RES_BITS-1:0] trial;

    assign idx_dn = fsm_q.idx - IW'(1);

    always_comb begin
        fsm_d    = fsm_q;
        fin      = 1'b0;
        trial    = fsm_q.sar;
        fin_code = fsm_q.sar;
        unique case (fsm_q.ph)
            PH_IDLE: begin
                if (go) begin
                    fsm_d.ph  = PH_SAMPLE;
                    fsm_d.cnt = SAMPLE_LD;
                end
            end
            PH_SAMPLE: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.ph  = PH_CONVERT;
                    fsm_d.cnt = STEP_LD;
                    fsm_d.idx = TOP_IDX;
                    fsm_d.sar = MSB_ONLY;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - CW'(1);
                end
            end
            PH_CONVERT: begin
                if (fsm_q.cnt != '0) begin
                    fsm_d.cnt = fsm_q.cnt - CW'(1);
                end else begin
                    if (!cmp_hi) begin
                        trial[fsm_q.idx] = 1'b0;
                    end
                    if (fsm_q.idx != '0) begin
                        trial[idx_dn] = 1'b1;
                        fsm_d.idx     = idx_dn;
                        fsm_d.cnt     = STEP_LD;
                    end else begin
                        fsm_d.ph = PH_IDLE;
                        fin      = 1'b1;
                    end
                    fsm_d.sar = trial;
                    fin_code  = trial;
                end
            end
            default: fsm_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{ph: PH_IDLE, cnt: '0, idx: '0, sar: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign busy     = (fsm_q.ph != PH_IDLE);
    assign sar_hold = (fsm_q.ph == PH_CONVERT);
    assign dac_code = fsm_q.sar;

    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sar_hold) |-> dac_code == MSB_ONLY);

    // R3
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sar_hold && $past(sar_hold) && fsm_q.cnt != STEP_LD) |-> $stable(dac_code));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.ph == PH_CONVERT) |=> (fsm_q.ph != PH_SAMPLE));

    // R6
    fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (!busy && !sar_hold));

endmodule

// File: rtl/sar_seq_regs.sv
module sar_seq_regs
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int DATA_W   = 16   // at least RES_BITS and 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                busy,
    input  logic                fin,
    input  logic [RES_BITS-1:0] fin_code,
    output logic                go,
    output logic                irq
);

    typedef struct packed {
        logic                ien;
        logic                done;
        logic                irq;
        logic [RES_BITS-1:0] res;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr, stat_rd;
    logic  unused_wdata;

    assign ctrl_wr      = bus_wr && (bus_addr == OFS_CTRL);
    assign stat_rd      = bus_rd && (bus_addr == OFS_STAT);
    assign go           = ctrl_wr && bus_wdata[CTRL_GO] && !busy;
    assign unused_wdata = ^bus_wdata[DATA_W-1:2];

    always_comb begin
        regs_d = regs_q;
        if (ctrl_wr) begin
            regs_d.ien = bus_wdata[CTRL_IEN];
        end
        if (go) begin
            regs_d.done = 1'b0;
        end
        if (stat_rd) begin
            regs_d.irq = 1'b0;
        end
        if (fin) begin
            regs_d.done = 1'b1;
            regs_d.res  = fin_code;
            if (regs_q.ien) begin
                regs_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{ien: 1'b0, done: 1'b0, irq: 1'b0, res: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: bus_rdata[CTRL_IEN] = regs_q.ien;
            OFS_STAT: begin
                bus_rdata[ST_BUSY] = busy;
                bus_rdata[ST_DONE] = regs_q.done;
                bus_rdata[ST_IRQ]  = regs_q.irq;
            end
            OFS_RES:  bus_rdata = DATA_W'(regs_q.res);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = regs_q.irq;

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(regs_q.res));

    // R2
    go_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !regs_q.done);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && regs_q.ien) |=> irq);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fin) |=> !irq);

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer #(
    parameter int RES_BITS   = 8,
    parameter int SAMPLE_CYC = 750,
    parameter int STEP_CYC   = 313,
    parameter int DATA_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sar_hold,
    output logic                irq
);

    logic                go, busy, fin;
    logic [RES_BITS-1:0] fin_code;

    sar_seq_regs #(
        .RES_BITS (RES_BITS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_code  (fin_code),
        .go        (go),
        .irq       (irq)
    );

    sar_seq_fsm #(
        .RES_BITS   (RES_BITS),
        .SAMPLE_CYC (SAMPLE_CYC),
        .STEP_CYC   (STEP_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .cmp_hi   (cmp_hi),
        .busy     (busy),
        .sar_hold (sar_hold),
        .dac_code (dac_code),
        .fin      (fin),
        .fin_code (fin_code)
    );

endmodule

// File: tb/sar_adc_sequencer_bench.sv
`timescale 1ns/1ps
module sar_adc_sequencer_bench;

    localparam int N     = 8;
    localparam int S     = 10;
    localparam int T     = 3;
    localparam int DW    = 16;
    localparam int TOTAL = S + N * T;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cmp_hi;
    logic [N-1:0]  dac_code;
    logic          sar_hold;
    logic          irq;
    logic [N-1:0]  vin = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Scoreboard queues: analogue input and start edge number
    int exp_vin[$];
    int exp_start[$];
    logic hold_prev = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Threshold model of the comparator and DAC
    assign cmp_hi = (vin >= dac_code);

    sar_adc_sequencer #(
        .RES_BITS(N), .SAMPLE_CYC(S), .STEP_CYC(T), .DATA_W(DW)
    ) u_sar_adc_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .sar_hold(sar_hold), .irq(irq)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: timing and trial codes against the queued expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (sar_hold && !hold_prev) begin
                if (exp_start.size() == 0) begin
                    check(1'b0, "R3 unexpected hold", 0, 1);
                end else begin
                    check(cyc - exp_start[0] == S, "R2 sample length", cyc - exp_start[0], S);
                    check(dac_code == 8'h80, "R4 first trial", dac_code, 8'h80);
                end
            end
            if (sar_hold && exp_start.size() > 0 && (cyc - exp_start[0] == S + T)) begin
                check(dac_code == ((exp_vin[0] & 8'h80) | 8'h40), "R4 second trial",
                      dac_code, (exp_vin[0] & 8'h80) | 8'h40);
            end
            if (!sar_hold && hold_prev && exp_start.size() > 0) begin
                check(cyc - exp_start[0] == TOTAL, "R3 R6 conversion length",
                      cyc - exp_start[0], TOTAL);
                check(dac_code == N'(exp_vin[0]), "R5 final code", dac_code, exp_vin[0]);
                void'(exp_vin.pop_front());
                void'(exp_start.pop_front());
            end
        end
        hold_prev = sar_hold;
    end

    task automatic run_conv(input logic [N-1:0] v, input logic ien, input logic poke,
                            input logic [N-1:0] prev);
        logic [DW-1:0] d;
        int st;
        vin = v;
        bus_write(2'd0, {14'd0, ien, 1'b1});
        st = cyc;
        exp_vin.push_back(int'(v));
        exp_start.push_back(st);
        bus_read(2'd1, d);
        check(d == 16'h1, "R2 busy set done clear", d, 16'h1);
        bus_read(2'd2, d);
        check(d == DW'(prev), "R8 result held during run", d, prev);
        bus_read(2'd0, d);
        check(d == {14'd0, ien, 1'b0}, "R9 R11 ctrl readback", d, {14'd0, ien, 1'b0});
        if (poke) begin
            bus_write(2'd0, {14'd0, ien, 1'b1});
            bus_read(2'd1, d);
            check(d[0] == 1'b1, "R7 busy after ignored start", d, 1);
        end
        while (cyc < st + TOTAL) @(negedge clk);
        check(irq == ien, "R9 irq at done", irq, ien);
        bus_read(2'd1, d);
        check(d == {13'd0, ien, 2'b10}, "R6 R11 status at done", d, {13'd0, ien, 2'b10});
        check(irq == 1'b0, "R10 irq cleared by status read", irq, 0);
        bus_read(2'd1, d);
        check(d == 16'h2, "R10 done kept after clear", d, 16'h2);
        bus_read(2'd2, d);
        check(d == DW'(v), "R5 R7 result register", d, v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(sar_hold == 1'b0, "R1 hold low", sar_hold, 0);
        check(irq == 1'b0, "R1 irq low", irq, 0);
        bus_read(2'd1, d);
        check(d == 16'h0, "R1 status zero", d, 0);
        bus_read(2'd2, d);
        check(d == 16'h0, "R1 result zero", d, 0);

        run_conv(8'hA5, 1'b1, 1'b0, 8'h00);
        run_conv(8'h00, 1'b0, 1'b0, 8'hA5);
        run_conv(8'hFF, 1'b1, 1'b1, 8'h00);
        run_conv(8'h80, 1'b0, 1'b0, 8'hFF);
        run_conv(8'h7F, 1'b1, 1'b0, 8'h80);
        run_conv(8'h01, 1'b0, 1'b1, 8'h7F);
        run_conv(8'h5A, 1'b1, 1'b0, 8'h01);

        repeat (4) @(negedge clk);
        check(exp_start.size() == 0, "R3 all conversions seen", exp_start.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule